// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Logic Array

This block is a small two-level logic array. Only its AND plane can be programmed. Every output owns a private group of product terms, and a hard-wired OR gate sums them. No term can be routed to another output. A function that two outputs both need must be written once into each output's group. A function that needs more terms than one group holds cannot be built.

Each stored term is a list of literal codes, one code per input. A configuration write replaces one term slot on a rising clock edge. The slot is addressed by the output group and by the term position inside that group. The input vector is evaluated combinationally, so the outputs follow the inputs within the same cycle.

Reset leaves every term disabled, so every output reads 0 until software-free configuration logic elsewhere on the chip programs the array. A term slot that a function does not need stays in the disabled code and adds nothing to its OR gate.

Top module: `pal_fixed_or`

## Requirements
- R1: While reset is asserted, and after it until the first write, every term slot holds the disabled code and every output reads 0 for every input value.
- R2: Bits [2i+1:2i] of a term hold the literal code for `in_vec[i]`. The codes are:
  - 00: the input does not participate.
  - 01: the term requires the input to be 1.
  - 10: the term requires the input to be 0.
  - 11: the whole term is forced to 0.
- R3: `out_vec[k]` is the OR of the N_TERM terms stored in group k. The group with all its slots in use realizes a four-term function.
- R4: When `cfg_we` is high at a rising edge, the slot addressed by (`cfg_out`, `cfg_term`) takes `cfg_lits`. Every other slot keeps its value.
- R5: When `cfg_we` is low at a rising edge, no slot changes, whatever the other configuration inputs carry.
- R6: Outputs respond to a change of `in_vec` combinationally, with no clock edge in between.
- R7: A write becomes visible only after the rising edge that captures it. Before that edge the outputs show the old contents.
- R8: A term whose literals are all 00 evaluates to constant 1.
- R9: The following four functions are programmed over inputs A=`in_vec[3]`, B=`in_vec[2]`, C=`in_vec[1]`, D=`in_vec[0]`:
  - group 3: W = A + BD + BC
  - group 2: X = BC'
  - group 1: Y = B + C
  - group 0: Z = A'B'C'D + BCD + AD' + B'CD'

  With that programming, inputs 0 to 9 yield the BCD-to-Gray mapping, for example 0101 gives `out_vec` = 1110.
- R10: A term written into group k affects `out_vec[k]` only. Terms are never shared between groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset; disables all terms |
| cfg_we | input | 1 | Write strobe for one term slot |
| cfg_out | input | $clog2(N_OUT) | Output group of the slot being written |
| cfg_term | input | $clog2(N_TERM) | Term position within the group |
| cfg_lits | input | 2*N_IN | Literal codes for the slot, two bits per input |
| in_vec | input | N_IN | Input vector evaluated by the array |
| out_vec | output | N_OUT | One sum-of-products result per group |

## Verification
The bench builds the array at its default size: four inputs, four outputs and four terms per group. At this size the full four-term function Z fits exactly in its group, and the BCD-to-Gray mapping can be walked value by value from a table.

The size also makes every input value enumerable, so the reset state is checked over all sixteen of them. Directed cases place a single all-don't-care term in one group to show it is isolated from the others. They also mix true, complemented and forced-0 literals, and observe the outputs on both sides of the capturing edge of a write.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        LIT_DC   = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;

endpackage

// File: rtl/pal_term_eval.sv
module pal_term_eval
    import pal_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [2*N_IN-1:0] lits,
    input  logic [N_IN-1:0]   in_vec,
    output logic              hit
);

    // One product term: every participating literal must match.
    always_comb begin
        hit = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            unique case (lit_e'(lits[2*i +: 2]))
                LIT_DC:   ;
                LIT_TRUE: if (!in_vec[i]) hit = 1'b0;
                LIT_COMP: if (in_vec[i])  hit = 1'b0;
                LIT_KILL: hit = 1'b0;
            endcase
        end
        // R8: a term with no participating literal is constant 1
        if (lits == '0) begin
            p_dontcare_one_r8: assert (hit == 1'b1);
        end
    end

endmodule

// File: rtl/pal_term_store.sv
module pal_term_store #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int N_TERM = 4,
    parameter int OW     = 2,
    parameter int TW     = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     we,
    input  logic [OW-1:0]                            out_idx,
    input  logic [TW-1:0]                            term_idx,
    input  logic [2*N_IN-1:0]                        lits,
    output logic [N_OUT*N_TERM-1:0][2*N_IN-1:0]      slots
);

    localparam int N_SLOT = N_OUT * N_TERM;
    localparam int SELW   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    logic [SELW-1:0] sel;
    logic            valid;

    always_comb begin
        valid = (int'(out_idx) < N_OUT) && (int'(term_idx) < N_TERM);
        sel   = SELW'(int'(out_idx) * N_TERM + int'(term_idx));
    end

    // Reset fills every literal with the kill code (all ones).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots <= '1;
        end else if (we && valid) begin
            slots[sel] <= lits;
        end
    end

    // R4: the addressed slot holds the written pattern after the edge
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && valid) |=> (slots[$past(sel)] == $past(lits)));

    // R5: without a write strobe nothing in storage moves
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(slots));

endmodule

// File: rtl/pal_fixed_or.sv
module pal_fixed_or #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int N_TERM = 4,
    localparam int OW    = (N_OUT  > 1) ? $clog2(N_OUT)  : 1,
    localparam int TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OW-1:0]     cfg_out,
    input  logic [TW-1:0]     cfg_term,
    input  logic [2*N_IN-1:0] cfg_lits,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);

    logic [N_OUT*N_TERM-1:0][2*N_IN-1:0] slots;

    pal_term_store #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .OW(OW), .TW(TW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .out_idx  (cfg_out),
        .term_idx (cfg_term),
        .lits     (cfg_lits),
        .slots    (slots)
    );

    // Fixed OR plane: each output sums only its own private terms.
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        logic [N_TERM-1:0] hits;
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            pal_term_eval #(.N_IN(N_IN)) u_term (
                .lits   (slots[g*N_TERM + t]),
                .in_vec (in_vec),
                .hit    (hits[t])
            );
        end
        assign out_vec[g] = |hits;
    end

    // R6: with storage untouched, outputs move only when the inputs do
    p_out_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> (!$stable(in_vec) || $stable(out_vec)));

endmodule

// File: tb/pal_fixed_or_test.sv
`timescale 1ns/1ps
module pal_fixed_or_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_out = '0;
    logic [1:0] cfg_term = '0;
    logic [7:0] cfg_lits = '0;
    logic [3:0] in_vec = '0;
    logic [3:0] out_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // {input nibble, expected W X Y Z}
    localparam logic [7:0] REF_TAB [10] = '{
        8'h00, 8'h11, 8'h23, 8'h32, 8'h46,
        8'h5E, 8'h6A, 8'h7B, 8'h89, 8'h98
    };

    always #5 clk = ~clk;

    pal_fixed_or uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_out(cfg_out),
        .cfg_term(cfg_term), .cfg_lits(cfg_lits), .in_vec(in_vec),
        .out_vec(out_vec)
    );

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (out_vec !== exp) begin
            failures++;
            $display("FAIL %s in=%b got=%b exp=%b", req, in_vec, out_vec, exp);
        end
    endtask

    task automatic wr(input logic [1:0] o, input logic [1:0] t, input logic [7:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_out = o; cfg_term = t; cfg_lits = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        // R1: every input value reads 0 after reset
        for (int v = 0; v < 16; v++) begin
            in_vec = 4'(v); #1;
            check("R1", 4'b0000);
        end

        // R8 / R10: an all-don't-care term in group 1 drives only out 1
        wr(2'd1, 2'd2, 8'h00);
        in_vec = 4'b0000; #1; check("R8", 4'b0010);
        in_vec = 4'b1111; #1; check("R10", 4'b0010);
        in_vec = 4'b1010; #1; check("R8", 4'b0010);

        // R2: A true in group 0 term 0
        wr(2'd0, 2'd0, 8'b01_00_00_00);
        in_vec = 4'b0000; #1; check("R2", 4'b0010);
        in_vec = 4'b1000; #1; check("R2", 4'b0011);
        // R2 / R3: add D complemented, so out0 = A | ~D
        wr(2'd0, 2'd1, 8'b00_00_00_10);
        in_vec = 4'b0001; #1; check("R2", 4'b0010);
        in_vec = 4'b0000; #1; check("R3", 4'b0011);
        // R2: a single kill literal disables a term otherwise always true
        wr(2'd0, 2'd2, 8'b00_00_11_00);
        in_vec = 4'b0001; #1; check("R2", 4'b0010);

        // R5: strobe low, data for an all-true term present, no change
        @(negedge clk);
        cfg_we = 1'b0; cfg_out = 2'd2; cfg_term = 2'd0; cfg_lits = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R5", 4'b0010);

        // R7: before the capturing edge old value, after it new value
        cfg_we = 1'b1; #1;
        check("R7", 4'b0010);
        @(posedge clk); #1;
        check("R4", 4'b0110);
        @(negedge clk); cfg_we = 1'b0;

        // R6: input changes with no clock edge
        in_vec = 4'b1000; #1; check("R6", 4'b0111);
        in_vec = 4'b0001; #1; check("R6", 4'b0110);

        // R1 again: reset clears all programming
        do_reset();
        in_vec = 4'b0101; #1; check("R1", 4'b0000);

        // R9 reference programming: W=3 X=2 Y=1 Z=0
        wr(2'd3, 2'd0, 8'b01_00_00_00);
        wr(2'd3, 2'd1, 8'b00_01_00_01);
        wr(2'd3, 2'd2, 8'b00_01_01_00);
        wr(2'd3, 2'd3, 8'hFF);
        wr(2'd2, 2'd0, 8'b00_01_10_00);
        wr(2'd1, 2'd0, 8'b00_01_00_00);
        wr(2'd1, 2'd1, 8'b00_00_01_00);
        wr(2'd0, 2'd0, 8'b10_10_10_01);
        wr(2'd0, 2'd1, 8'b00_01_01_01);
        wr(2'd0, 2'd2, 8'b01_00_00_10);
        wr(2'd0, 2'd3, 8'b00_10_01_10);
        for (int k = 0; k < 10; k++) begin
            in_vec = REF_TAB[k][7:4]; #1;
            check("R9", REF_TAB[k][3:0]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule